// File: doc/BRIEF.md
# Numerically Controlled Phase Generator with Selectable Tuning and Offset Words

This block is the digital core of a direct digital synthesizer. A 28-bit accumulator adds a tuning word on every clock, so the output frequency is the tuning word times the clock rate divided by 2^28. The block holds two tuning words and two 12-bit phase offsets. Two select pins choose which tuning word drives the accumulator and which offset is added to its top twelve bits. Toggling the frequency select gives binary FSK. Toggling the phase select gives fast PSK. The 12-bit result feeds a phase-to-amplitude stage downstream.

All four words are loaded through a small write port: a strobe, a two-bit address and a data field. A synchronous clear input holds the accumulator at zero and leaves the write port working. Words can therefore be preloaded during the clear. Several instances that share a clock and leave the clear on the same edge stay phase-coherent. An asynchronous active-low reset returns every register to zero at power-up.

Top module: `nco_phase_gen`

## Requirements
- R1: On every rising clock edge where `sync_clr` is low, the accumulator takes its old value plus the selected tuning word, modulo 2^28.
- R2: A tuning word of 0x7FFFFFF makes the accumulator overflow once every two clocks, so `phase_o` alternates between two values.
- R3: With `fsel` at 0 the accumulator adds the tuning word at address 0. With `fsel` at 1 it adds the tuning word at address 1.
- R4: Changing `fsel`, or writing a tuning word, leaves the accumulator contents untouched. Only the step size used from that edge on changes, so the phase stays continuous.
- R5: At each edge, `phase_o` is loaded with accumulator bits 27:16 plus the selected offset, modulo 4096. The accumulator value used is the one stored at that same edge. The lower 16 accumulator bits are dropped.
- R6: With `psel` at 0 the offset at address 2 is added. With `psel` at 1 the offset at address 3 is added.
- R7: An edge with `sync_clr` high loads the accumulator with zero and sets `phase_o` to the selected offset. Writes made during the clear still take effect.
- R8: When `wr_en` is high at an edge, the word at `wr_addr` is loaded at that edge:
  - address 0 loads tuning word 0 from all 28 data bits;
  - address 1 loads tuning word 1 from all 28 data bits;
  - address 2 loads offset 0 from data bits 11:0;
  - address 3 loads offset 1 from data bits 11:0.

  The new word is first used at the next edge. The other three words keep their values.
- R9: A low `rst_n` clears the accumulator, all four words and `phase_o` to zero at once, without waiting for a clock.
- R10: With a tuning word of 1, `phase_o` steps by one only once every 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous accumulator clear |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word address: 0/1 tuning, 2/3 offset |
| wr_data | input | 28 | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 1 | Phase offset select |
| phase_o | output | 12 | Registered output phase |

## Verification
The accumulator and `phase_o` update on the same rising edge. The select pins and the clear apply at the edge where they are sampled. A written word first shows up one edge after its strobe. The bench drives inputs on the falling edge and advances its own model at each rising edge. Its model uses the words as they were before that edge, and only then applies any write. It compares `phase_o` on the following falling edge, so every check lands exactly one register stage after its stimulus.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W  = 28;
  localparam int PH_W   = 12;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FREQ0  = 2'd0,
    ADDR_FREQ1  = 2'd1,
    ADDR_PHASE0 = 2'd2,
    ADDR_PHASE1 = 2'd3
  } nco_addr_e;
endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank
  import nco_pkg::*;
#(
  parameter int ACC_BITS = ACC_W,
  parameter int PH_BITS  = PH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ACC_BITS-1:0] wr_data,
  input  logic                fsel,
  input  logic                psel,
  output logic [ACC_BITS-1:0] step_o,
  output logic [PH_BITS-1:0]  off_o
);
  localparam int NBANK = 2;

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(gi);
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(gi + NBANK);
    logic                fwe, pwe;
    logic [ACC_BITS-1:0] fq;
    logic [PH_BITS-1:0]  pq;

    always_comb begin
      fwe = wr_en && (wr_addr == FADDR);
      pwe = wr_en && (wr_addr == PADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fq <= '0;
      else if (fwe) fq <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pq <= '0;
      else if (pwe) pq <= wr_data[PH_BITS-1:0];
    end
  end

  always_comb begin
    step_o = fsel ? g_bank[1].fq : g_bank[0].fq;
    off_o  = psel ? g_bank[1].pq : g_bank[0].pq;
  end

  // R8: tuning word 0 holds the written data one edge later
  p_wr_freq0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_FREQ0) |=> (g_bank[0].fq == $past(wr_data)));

  // R8: an offset write leaves both tuning words unchanged
  p_keep_freq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1]) |=> ($stable(g_bank[0].fq) && $stable(g_bank[1].fq)));
endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int ACC_BITS = ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic [ACC_BITS-1:0] step,
  output logic [ACC_BITS-1:0] acc_d
);
  logic [ACC_BITS-1:0] acc_q;

  always_comb begin
    if (sync_clr) acc_d = '0;
    else          acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R7: clear gives the known starting phase
  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (acc_q == '0));

  // R4: a zero step leaves the accumulator untouched
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && step == '0) |=> $stable(acc_q));
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
  import nco_pkg::*;
#(
  parameter int PH_BITS = PH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PH_BITS-1:0] acc_top,
  input  logic [PH_BITS-1:0] off,
  output logic [PH_BITS-1:0] phase_q
);
  logic [PH_BITS-1:0] phase_d;

  always_comb phase_d = acc_top + off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
  import nco_pkg::*;
#(
  parameter int ACC_BITS = ACC_W,
  parameter int PH_BITS  = PH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ACC_BITS-1:0] wr_data,
  input  logic                fsel,
  input  logic                psel,
  output logic [PH_BITS-1:0]  phase_o
);
  localparam int TOP_LSB = ACC_BITS - PH_BITS;

  logic [ACC_BITS-1:0] step_w;
  logic [PH_BITS-1:0]  off_w;
  logic [ACC_BITS-1:0] acc_next;

  nco_word_bank #(.ACC_BITS(ACC_BITS), .PH_BITS(PH_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsel(fsel), .psel(psel),
    .step_o(step_w), .off_o(off_w)
  );

  nco_accum #(.ACC_BITS(ACC_BITS)) u_acc (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr),
    .step(step_w), .acc_d(acc_next)
  );

  nco_phase_out #(.PH_BITS(PH_BITS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .acc_top(acc_next[ACC_BITS-1:TOP_LSB]), .off(off_w),
    .phase_q(phase_o)
  );

  // R7: during a clear the output is exactly the selected offset
  p_clr_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (phase_o == $past(off_w)));
endmodule

// File: tb/test_nco_phase_gen.sv
module test_nco_phase_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, sync_clr, wr_en, fsel, psel;
  logic [1:0]  wr_addr;
  logic [27:0] wr_data;
  logic [11:0] phase_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [27:0] mf [2];
  logic [11:0] mp [2];
  logic [27:0] macc;
  logic [11:0] mexp;

  // each entry: {sync_clr, fsel, psel, cycle count}
  localparam logic [10:0] TBL [6] = '{
    {1'b0, 1'b0, 1'b0, 8'd20},
    {1'b0, 1'b1, 1'b0, 8'd10},
    {1'b0, 1'b0, 1'b1, 8'd5},
    {1'b0, 1'b1, 1'b1, 8'd7},
    {1'b1, 1'b0, 1'b1, 8'd2},
    {1'b0, 1'b0, 1'b0, 8'd3}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_phase_gen i_nco_phase_gen (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .fsel(fsel), .psel(psel),
    .phase_o(phase_o)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_o=%h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; applies inputs, models the rising edge, checks on the next falling edge
  task automatic cyc(input string tag, input logic clr, input logic fs, input logic ps,
                     input logic we, input logic [1:0] ad, input logic [27:0] dat);
    sync_clr = clr; fsel = fs; psel = ps;
    wr_en = we; wr_addr = ad; wr_data = dat;
    @(posedge clk);
    macc = clr ? 28'd0 : macc + mf[fs];
    mexp = 12'(macc >> 16) + mp[ps];
    if (we) begin
      case (ad)
        2'd0: mf[0] = dat;
        2'd1: mf[1] = dat;
        2'd2: mp[0] = dat[11:0];
        default: mp[1] = dat[11:0];
      endcase
    end
    @(negedge clk);
    chk(tag, phase_o, mexp);
  endtask

  task automatic model_reset();
    mf[0] = '0; mf[1] = '0; mp[0] = '0; mp[1] = '0; macc = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_clr = 1'b0; wr_en = 1'b0; fsel = 1'b0; psel = 1'b0;
    wr_addr = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R9 reset state", phase_o, 12'h000);
    rst_n = 1'b1;

    // R7: preload while cleared; output follows the selected offset
    cyc("R7 clear load f0", 1, 0, 0, 1, 2'd0, 28'h100_0000);
    cyc("R7 clear load f1", 1, 0, 0, 1, 2'd1, 28'h030_0000);
    cyc("R7 clear load p1", 1, 0, 1, 1, 2'd3, 28'h000_0400);
    cyc("R7 clear shows p1", 1, 0, 1, 0, 2'd0, 28'h0);
    chk("R7 offset during clear", phase_o, 12'h400);
    cyc("R7 clear p0", 1, 0, 0, 0, 2'd0, 28'h0);
    chk("R7 zero offset during clear", phase_o, 12'h000);

    // R1 R3 R5 R6: table of select patterns
    for (int e = 0; e < 6; e++) begin
      for (int c = 0; c < int'(TBL[e][7:0]); c++)
        cyc($sformatf("R1/R3/R6 table entry %0d cycle %0d", e, c),
            TBL[e][10], TBL[e][9], TBL[e][8], 0, 2'd0, 28'h0);
    end

    // R4 R8: rewrite the active word mid-run, then hop between words
    cyc("R8 write f0 while active", 0, 0, 0, 1, 2'd0, 28'h0ab_cdef);
    cyc("R8 new f0 used next edge", 0, 0, 0, 0, 2'd0, 28'h0);
    cyc("R4 hop to f1", 0, 1, 0, 1, 2'd2, 28'hfff_f123);
    cyc("R4 hop back to f0", 0, 0, 0, 0, 2'd0, 28'h0);
    cyc("R5 offset wraps mod 4096", 0, 0, 0, 0, 2'd0, 28'h0);

    // R2: Nyquist-limit tuning word alternates the phase
    cyc("R2 load", 1, 0, 0, 1, 2'd0, 28'h7ff_ffff);
    cyc("R2 load p0", 1, 0, 0, 1, 2'd2, 28'h0);
    cyc("R2 step a", 0, 0, 0, 0, 2'd0, 28'h0);
    chk("R2 first half", phase_o, 12'h7ff);
    cyc("R2 step b", 0, 0, 0, 0, 2'd0, 28'h0);
    chk("R2 second half", phase_o, 12'hfff);
    cyc("R2 step c", 0, 0, 0, 0, 2'd0, 28'h0);
    chk("R2 wrapped", phase_o, 12'h7ff);

    // R10: tuning word 1 advances the output only every 65536 clocks
    cyc("R10 load", 1, 0, 0, 1, 2'd0, 28'h000_0001);
    for (int c = 0; c < 65535; c++)
      cyc("R10 slow ramp", 0, 0, 0, 0, 2'd0, 28'h0);
    chk("R10 still zero", phase_o, 12'h000);
    cyc("R10 first step", 0, 0, 0, 0, 2'd0, 28'h0);
    chk("R10 stepped", phase_o, 12'h001);

    // R9: asynchronous reset mid-run clears words and accumulator
    cyc("R9 prep", 0, 0, 0, 1, 2'd0, 28'h123_4567);
    cyc("R9 prep run", 0, 0, 0, 0, 2'd0, 28'h0);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1 chk("R9 async clear", phase_o, 12'h000);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R9 words cleared", 0, 0, 0, 0, 2'd0, 28'h0);
    chk("R9 stays zero", phase_o, 12'h000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule